// File: doc/BRIEF.md
# Two-Peak Trace Signature Matcher

This block inspects one preprocessed magnitude trace at a time. A one-cycle start pulse opens the trace and a one-cycle end pulse closes it. Each accepted sample is compared with a programmable threshold, and every run of samples above that threshold forms a peak region. For each region the block records the index of its largest sample. Only the first two regions of a trace are kept.

One cycle after the end pulse, the block gives a single-cycle verdict. The verdict states whether the distance between the two recorded peaks lies within one tenth of a programmed reference distance. It also gives the signed distance from the first peak to a programmed reference index. A realignment stage downstream can shift the stored trace by that amount, and a mapping stage can use the verdict to decide whether a probe position shows the wanted activity.

Top module: `trace_sig_match`

## Requirements
- R1: While reset is held, and after it is released until the first verdict, resultValid, spacingMatch, offsetValid and peakShift are all zero.
- R2: A sample lies above threshold only when it is strictly greater than the threshold. A sample equal to the threshold is not above it.
- R3: A peak region starts at an above-threshold sample whose preceding accepted sample was not above threshold, or that is the first sample of the trace. The region ends at the next sample that is not above threshold.
- R4: The recorded peak index is the 0-based position, counted over the samples accepted since the start pulse, of the largest sample in the region. When several samples share the maximum, the earliest one is recorded.
- R5: Only the first two regions of a trace are recorded. Any later region has no effect on the verdict.
- R6: With two regions recorded, let d = second peak index minus first peak index. spacingMatch is 1 exactly when |d - refSpacing| * 10 <= refSpacing, and the boundary is inclusive.
- R7: With two regions recorded, offsetValid is 1 and peakShift equals the first peak index minus refIndex, as an IDX_W+1-bit two's complement value.
- R8: If fewer than two regions were seen, the verdict has spacingMatch = 0, offsetValid = 0 and peakShift = 0.
- R9: The verdict appears in the cycle after the end pulse is sampled and lasts exactly one cycle. Outside that cycle, all four result outputs are zero.
- R10: Samples are accepted only while a trace is open. A sampleValid in the same cycle as a start or end pulse is ignored. An end pulse while no trace is open gives no verdict.
- R11: A start pulse while a trace is open discards everything collected and begins a new trace.
- R12: A region that is still above threshold when the end pulse arrives counts as a recorded region, using its maximum so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| traceStart | input | 1 | One-cycle pulse that opens a trace |
| traceEnd | input | 1 | One-cycle pulse that closes the open trace |
| sampleValid | input | 1 | sampleData carries a trace sample this cycle |
| sampleData | input | DATA_W | Unsigned magnitude sample |
| threshold | input | DATA_W | Peak detection threshold |
| refSpacing | input | IDX_W | Reference distance between the two peaks |
| refIndex | input | IDX_W | Reference position of the first peak |
| resultValid | output | 1 | Verdict strobe, one cycle |
| spacingMatch | output | 1 | Peak distance lies within tolerance |
| offsetValid | output | 1 | Two peaks were found, so peakShift is meaningful |
| peakShift | output | IDX_W+1 | Signed first-peak index minus refIndex |

## Verification
The spacing test is driven with single-sample peaks placed exactly at the reference distance and at one step inside and one step outside both tolerance edges. This separates an inclusive comparison from an exclusive one and catches an error in the sign of the difference. Wide regions with tied maxima, a sample exactly equal to the threshold, a third region, and a region still open at the end show whether region framing and maximum tracking are correct. Traces with zero or one region, a start pulse that arrives with a sample, stray samples and an end pulse outside any trace, and a restart in the middle of a trace show whether framing and the invalid-offset path are correct. A behavioural model in the bench follows every cycle and checks each output against its own expected values.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} ctrlState_t;

  typedef struct packed {
    logic clearAll;
    logic takeSample;
    logic finish;
  } ctrlStrobe_t;
endpackage

// File: rtl/tsm_ctrl.sv
module tsm_ctrl
  import tsm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        traceStart,
  input  logic        traceEnd,
  input  logic        sampleValid,
  output ctrlStrobe_t strobe
);
  ctrlState_t state, nextState;

  // A start pulse always wins. Inside a trace, an end pulse wins over a sample.
  always_comb begin
    strobe    = '0;
    nextState = state;
    if (traceStart) begin
      strobe.clearAll = 1'b1;
      nextState       = ST_RUN;
    end else if (state == ST_RUN) begin
      if (traceEnd) begin
        strobe.finish = 1'b1;
        nextState     = ST_IDLE;
      end else if (sampleValid) begin
        strobe.takeSample = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end
endmodule

// File: rtl/tsm_datapath.sv
module tsm_datapath
  import tsm_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 10,
  parameter int TOL_DIV = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobe_t              strobe,
  input  logic [DATA_W-1:0]        sampleData,
  input  logic [DATA_W-1:0]        threshold,
  input  logic [IDX_W-1:0]         refSpacing,
  input  logic [IDX_W-1:0]         refIndex,
  output logic                     resultValid,
  output logic                     spacingMatch,
  output logic                     offsetValid,
  output logic signed [IDX_W:0]    peakShift
);
  localparam int NUM_SLOTS = 2;
  localparam int CNT_W     = $clog2(NUM_SLOTS + 1);
  localparam int ERR_W     = IDX_W + 2 + $clog2(TOL_DIV + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0]  sampleIdx;
  logic              prevAbove;
  logic              tracking;
  logic              slotSel;
  logic [CNT_W-1:0]  regionCount;
  logic [IDX_W-1:0]  peakIdx [NUM_SLOTS];
  logic [DATA_W-1:0] peakVal [NUM_SLOTS];

  logic isAbove, riseEdge, slotFree, openSlot, growPeak;
  logic [CNT_W-1:0] nextCount;

  assign isAbove   = sampleData > threshold;
  assign riseEdge  = isAbove && !prevAbove;
  assign slotFree  = regionCount < CNT_W'(NUM_SLOTS);
  assign openSlot  = strobe.takeSample && riseEdge && slotFree;
  assign growPeak  = strobe.takeSample && isAbove && !riseEdge && tracking
                     && (sampleData > peakVal[slotSel]);
  assign nextCount = regionCount + CNT_W'(1);

  // Sequencing state: index counter, region framing, slot choice
  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clearAll) begin
      sampleIdx   <= '0;
      prevAbove   <= 1'b0;
      tracking    <= 1'b0;
      slotSel     <= 1'b0;
      regionCount <= '0;
    end else if (strobe.takeSample) begin
      prevAbove <= isAbove;
      if (sampleIdx != IDX_MAX) sampleIdx <= sampleIdx + IDX_W'(1);
      if (riseEdge) begin
        if (slotFree) begin
          slotSel     <= regionCount[0];
          regionCount <= nextCount;
          tracking    <= 1'b1;
        end else begin
          tracking <= 1'b0;
        end
      end else if (!isAbove) begin
        tracking <= 1'b0;
      end
    end
  end

  // One storage slot per kept peak
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic loadNew, loadMax;
    assign loadNew = openSlot && (regionCount == CNT_W'(g));
    assign loadMax = growPeak && (slotSel == g[0]);
    always_ff @(posedge clk) begin
      if (!rst_n || strobe.clearAll) begin
        peakIdx[g] <= '0;
        peakVal[g] <= '0;
      end else if (loadNew || loadMax) begin
        peakIdx[g] <= sampleIdx;
        peakVal[g] <= sampleData;
      end
    end
  end

  // Verdict arithmetic, integer only
  logic              havePair;
  logic [IDX_W:0]    spacing;
  logic [IDX_W:0]    refExt;
  logic [IDX_W:0]    errMag;
  logic [ERR_W-1:0]  errScaled;
  logic              withinTol;
  logic signed [IDX_W:0] shiftCalc;

  assign havePair  = regionCount == CNT_W'(NUM_SLOTS);
  assign spacing   = {1'b0, peakIdx[1]} - {1'b0, peakIdx[0]};
  assign refExt    = {1'b0, refSpacing};
  assign errMag    = (spacing >= refExt) ? (spacing - refExt) : (refExt - spacing);
  assign errScaled = ERR_W'(errMag) * ERR_W'(TOL_DIV);
  assign withinTol = errScaled <= ERR_W'(refSpacing);
  assign shiftCalc = $signed({1'b0, peakIdx[0]}) - $signed({1'b0, refIndex});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultValid  <= 1'b0;
      spacingMatch <= 1'b0;
      offsetValid  <= 1'b0;
      peakShift    <= '0;
    end else begin
      resultValid  <= strobe.finish;
      spacingMatch <= strobe.finish && havePair && withinTol;
      offsetValid  <= strobe.finish && havePair;
      peakShift    <= (strobe.finish && havePair) ? shiftCalc : '0;
    end
  end
endmodule

// File: rtl/trace_sig_match.sv
module trace_sig_match
  import tsm_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 10,
  parameter int TOL_DIV = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  traceStart,
  input  logic                  traceEnd,
  input  logic                  sampleValid,
  input  logic [DATA_W-1:0]     sampleData,
  input  logic [DATA_W-1:0]     threshold,
  input  logic [IDX_W-1:0]      refSpacing,
  input  logic [IDX_W-1:0]      refIndex,
  output logic                  resultValid,
  output logic                  spacingMatch,
  output logic                  offsetValid,
  output logic signed [IDX_W:0] peakShift
);
  ctrlStrobe_t strobe;

  tsm_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .traceStart (traceStart),
    .traceEnd   (traceEnd),
    .sampleValid(sampleValid),
    .strobe     (strobe)
  );

  tsm_datapath #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .TOL_DIV(TOL_DIV)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .sampleData  (sampleData),
    .threshold   (threshold),
    .refSpacing  (refSpacing),
    .refIndex    (refIndex),
    .resultValid (resultValid),
    .spacingMatch(spacingMatch),
    .offsetValid (offsetValid),
    .peakShift   (peakShift)
  );
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
  parameter int IDX_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  traceEnd,
  input logic                  resultValid,
  input logic                  spacingMatch,
  input logic                  offsetValid,
  input logic signed [IDX_W:0] peakShift
);
  // R9: the verdict strobe is a single cycle
  p_result_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R10: a verdict is always preceded by an end pulse
  p_result_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> $past(traceEnd));

  // R9: result fields stay quiet outside the verdict cycle
  p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> (!spacingMatch && !offsetValid && peakShift == '0));

  // R8: a match is only possible with two recorded peaks
  p_match_needs_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spacingMatch |-> offsetValid);

  // R8: without a pair the shift is reported as zero
  p_shift_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && !offsetValid) |-> (peakShift == '0));
endmodule

bind trace_sig_match tsm_checker #(.IDX_W(IDX_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .traceEnd    (traceEnd),
  .resultValid (resultValid),
  .spacingMatch(spacingMatch),
  .offsetValid (offsetValid),
  .peakShift   (peakShift)
);

// File: tb/test_trace_sig_match.sv
`timescale 1ns/1ps
module test_trace_sig_match;
  localparam int DATA_W = 12;
  localparam int IDX_W  = 10;
  localparam int THR    = 100;
  localparam int REFSP  = 20;
  localparam int REFIX  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic traceStart = 1'b0, traceEnd = 1'b0, sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic [DATA_W-1:0] threshold = DATA_W'(THR);
  logic [IDX_W-1:0]  refSpacing = IDX_W'(REFSP);
  logic [IDX_W-1:0]  refIndex = IDX_W'(REFIX);
  logic resultValid, spacingMatch, offsetValid;
  logic signed [IDX_W:0] peakShift;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string curReq = "R1";
  int stim[$];

  always #5 clk = ~clk;

  trace_sig_match i_trace_sig_match (
    .clk(clk), .rst_n(rst_n), .traceStart(traceStart), .traceEnd(traceEnd),
    .sampleValid(sampleValid), .sampleData(sampleData), .threshold(threshold),
    .refSpacing(refSpacing), .refIndex(refIndex), .resultValid(resultValid),
    .spacingMatch(spacingMatch), .offsetValid(offsetValid), .peakShift(peakShift)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mq[$];
  bit mOpen = 0;
  int eValid = 0, eMatch = 0, eOv = 0, eShift = 0;

  function automatic void judge(output int m, output int ov, output int sh);
    int n = 0;
    int pk[2];
    int pv[2];
    bit prev = 0;
    bit trk = 0;
    int d, e;
    foreach (mq[i]) begin
      bit ab = mq[i] > THR;
      if (ab && !prev) begin
        if (n < 2) begin pk[n] = i; pv[n] = mq[i]; n++; trk = 1; end
        else trk = 0;
      end else if (ab && trk && mq[i] > pv[n-1]) begin
        pk[n-1] = i; pv[n-1] = mq[i];
      end
      prev = ab;
    end
    if (n < 2) begin m = 0; ov = 0; sh = 0; end
    else begin
      d = pk[1] - pk[0];
      e = (d > REFSP) ? d - REFSP : REFSP - d;
      m = (e * 10 <= REFSP) ? 1 : 0;
      ov = 1;
      sh = pk[0] - REFIX;
    end
  endfunction

  always @(posedge clk) begin
    eValid = 0; eMatch = 0; eOv = 0; eShift = 0;
    if (!rst_n) begin
      mOpen = 0;
      mq.delete();
    end else if (traceStart) begin
      mOpen = 1;
      mq.delete();
    end else if (mOpen && traceEnd) begin
      mOpen = 0;
      eValid = 1;
      judge(eMatch, eOv, eShift);
    end else if (mOpen && sampleValid) begin
      mq.push_back(int'(sampleData));
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checkEq(curReq, "resultValid", int'(resultValid), eValid);
      checkEq(curReq, "spacingMatch", int'(spacingMatch), eMatch);
      checkEq(curReq, "offsetValid", int'(offsetValid), eOv);
      checkEq(curReq, "peakShift", int'(peakShift), eShift);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic makeStim(input int len, input int a, input int b, input int c);
    stim.delete();
    for (int i = 0; i < len; i++) stim.push_back(10);
    if (a >= 0) stim[a] = 200;
    if (b >= 0) stim[b] = 200;
    if (c >= 0) stim[c] = 200;
  endtask

  task automatic runTrace(input bit sampleOnStart);
    traceStart = 1'b1;
    sampleValid = sampleOnStart;
    sampleData = DATA_W'(300);
    @(negedge clk);
    traceStart = 1'b0;
    foreach (stim[i]) begin
      sampleValid = 1'b1;
      sampleData = DATA_W'(stim[i]);
      @(negedge clk);
    end
    sampleValid = 1'b0;
    traceEnd = 1'b1;
    @(negedge clk);
    traceEnd = 1'b0;
  endtask

  task automatic expectVerdict(input string req, input int m, input int ov, input int sh);
    checkEq(req, "verdict resultValid", int'(resultValid), 1);
    checkEq(req, "verdict spacingMatch", int'(spacingMatch), m);
    checkEq(req, "verdict offsetValid", int'(offsetValid), ov);
    checkEq(req, "verdict peakShift", int'(peakShift), sh);
  endtask

  initial begin
    // R1: reset state
    @(negedge clk);
    checkEq("R1", "reset resultValid", int'(resultValid), 0);
    checkEq("R1", "reset peakShift", int'(peakShift), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // R6 R7: exact reference spacing, negative shift
    curReq = "R6";
    makeStim(30, 3, 23, -1); runTrace(0); expectVerdict("R6", 1, 1, -2);
    @(negedge clk);
    checkEq("R9", "pulse ends", int'(resultValid), 0);

    // R6: tolerance edges (+2 inside, +3 outside, -2 inside, -3 outside)
    makeStim(40, 8, 30, -1); runTrace(0); expectVerdict("R6", 1, 1, 3);
    makeStim(40, 8, 31, -1); runTrace(0); expectVerdict("R6", 0, 1, 3);
    makeStim(30, 2, 20, -1); runTrace(0); expectVerdict("R6", 1, 1, -3);
    makeStim(30, 2, 19, -1); runTrace(0); expectVerdict("R6", 0, 1, -3);

    // R7: positive shift
    curReq = "R7";
    makeStim(50, 12, 32, -1); runTrace(0); expectVerdict("R7", 1, 1, 7);

    // R5: a third region is ignored
    curReq = "R5";
    makeStim(40, 4, 24, 26); runTrace(0); expectVerdict("R5", 1, 1, -1);

    // R8: one region and no region
    curReq = "R8";
    makeStim(30, 6, -1, -1); runTrace(0); expectVerdict("R8", 0, 0, 0);
    makeStim(10, -1, -1, -1); runTrace(0); expectVerdict("R8", 0, 0, 0);

    // R2: a sample equal to the threshold is not a peak
    curReq = "R2";
    makeStim(30, 3, 23, -1); stim[10] = THR; runTrace(0); expectVerdict("R2", 1, 1, -2);

    // R3 R4: wide region with a tied maximum keeps the earliest index
    curReq = "R4";
    makeStim(30, -1, 23, -1);
    stim[3] = 150; stim[4] = 180; stim[5] = 180; stim[6] = 120;
    runTrace(0); expectVerdict("R4", 1, 1, -1);

    // R3: two regions that touch through a below-threshold dip stay separate
    curReq = "R3";
    makeStim(30, 3, 5, -1); runTrace(0); expectVerdict("R3", 0, 1, -2);

    // R12: region still open at the end
    curReq = "R12";
    makeStim(25, 2, -1, -1); stim[23] = 150; stim[24] = 170;
    runTrace(0); expectVerdict("R12", 1, 1, -3);

    // R10: stray samples and an end pulse outside a trace
    curReq = "R10";
    sampleValid = 1'b1; sampleData = DATA_W'(300);
    repeat (3) @(negedge clk);
    sampleValid = 1'b0;
    traceEnd = 1'b1; @(negedge clk); traceEnd = 1'b0;
    @(negedge clk);
    checkEq("R10", "no verdict without trace", int'(resultValid), 0);
    // R10: sample in the start cycle is not counted
    makeStim(30, 3, 23, -1); runTrace(1); expectVerdict("R10", 1, 1, -2);

    // R11: restart in the middle of a trace
    curReq = "R11";
    traceStart = 1'b1; @(negedge clk); traceStart = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sampleValid = 1'b1; sampleData = DATA_W'((i == 1) ? 250 : 10); @(negedge clk);
    end
    sampleValid = 1'b0;
    makeStim(40, 9, 29, -1); runTrace(0); expectVerdict("R11", 1, 1, 4);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule